// File: doc/BRIEF.md
# Filtered PCIe TLP Bandwidth Counter

This block measures PCIe traffic for performance monitoring. It takes one TLP descriptor per accepted stream beat: the root-port index, the requester BDF, the header length and the payload length in DW, and an event class. A set of programmable filters decides whether the TLP adds to a saturating accumulator, and what it adds. The filters are a target filter, a one-shot trigger, a threshold window and a length-composition select. The target filter is either a root-port bitmap or a requester-BDF match.

Software programs the filters through a small word-addressed register port. Writes take effect at the clock edge. Reads are combinational from the current address. The descriptor stream uses valid/ready. The block never applies back-pressure, so `in_ready` is held high after reset. A beat is consumed on every cycle in which `in_valid` is high, and a producer may present a new descriptor on every cycle. The counter is `CNT_W` bits wide (64 by default) and is read as two 32-bit halves.

Top module: `tlp_bw_counter`

Register map (word address on `cfg_addr`):
- 0: control
- 1: filter values
- 2: counter low half
- 3: counter high half
- 4: status

## Requirements
- R1: After reset the counter reads 0, status reads 0, the filter word reads 0, and the control word reads 0x180.
  - The control word holds these fields: run at bit 0, port filter on at bit 1, BDF filter on at bit 2, trigger on at bit 3, trigger direction at bit 4, threshold on at bit 5, threshold direction at bit 6, length select at bits 8:7, selected class at bits 10:9, trigger exponent at bits 14:11, threshold exponent at bits 18:15.
  - The status word holds these bits: bit 0 overflow, bit 1 armed, bit 2 length-select error, bit 3 configuration error.
- R2: A TLP adds nothing when run is 0, or when its class differs from the selected class. Class codes are 0 bandwidth, 1 application layer, 2 transaction layer and 3 data-link layer.
- R3: The length select decides what a counted TLP adds: 2'b01 adds the payload DW, 2'b10 adds the header DW, and 2'b11 adds both.
- R4: With length select 2'b00 the counter holds its value and status bit 2 is set.
- R5: With the port filter on, a TLP counts only if the bit of the filter word (bits 15:0) indexed by its port is set.
- R6: For classes 2 and 3 with the port filter on, exactly one bitmap bit must be set. Any other count of set bits is a configuration error: status bit 3 is set and nothing counts. Class 1 accepts any number of bits.
- R7: With the BDF filter on, only TLPs whose requester BDF equals filter bits 31:16 count. Two settings are configuration errors that block counting: both target filters on at once, and the BDF filter on with a class other than 0.
- R8: With the trigger on and direction 0, nothing counts until the first TLP whose length (header plus payload) exceeds 2^exponent DW. That TLP counts, status bit 1 sets, and counting continues until a clear.
- R9: With the trigger on and direction 1, counting starts at the first TLP whose length is below 2^exponent DW.
- R10: With the threshold on, a TLP counts only if its length is at least 2^exponent DW (direction 0) or below 2^exponent DW (direction 1). The trigger and the threshold act only on class 0.
- R11: The counter saturates at all ones and sets status bit 0, which stays set until a clear. The counter never decreases except on a clear.
- R12: A control write with bit 31 set zeroes the counter, the overflow bit and the armed state. The control fields of that same write are stored. A TLP accepted in the clear cycle is dropped.
- R13: `in_ready` is 1 out of reset, and the counter changes only on a cycle with `in_valid` high or a clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Descriptor valid |
| in_ready | output | 1 | Descriptor accepted (always high) |
| in_port | input | PORT_W (4) | Root-port index |
| in_bdf | input | 16 | Requester BDF |
| in_hdr_dw | input | HDR_W (3) | Header length in DW |
| in_pay_dw | input | PAY_W (11) | Payload length in DW |
| in_cls | input | 2 | Event class |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register word address |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data |

## Verification
The checker watches, on every cycle, the properties that hold regardless of configuration:
- the counter is stable on idle cycles;
- a clear lands one edge later;
- the overflow and armed bits are sticky;
- the counter is monotonic between clears;
- the counter is frozen under a reserved length select.

Only the bench's directed scenarios can show which TLP values pass each filter. That covers the exact amounts added per length select, the edge cases where a trigger length equals its limit, the inclusive and exclusive edges of the threshold window, the configuration-error cases, and the exact point of saturation.

// File: rtl/tlp_bw_pkg.sv
package tlp_bw_pkg;

  typedef enum logic [1:0] {
    CLS_BW  = 2'd0,
    CLS_APP = 2'd1,
    CLS_TXN = 2'd2,
    CLS_LNK = 2'd3
  } evt_cls_e;

  // control word, LSB first: run, port_on, bdf_on, trig_on, trig_below,
  // thr_on, thr_below, len_sel[1:0], cls[1:0], trig_exp[3:0], thr_exp[3:0]
  typedef struct packed {
    logic [3:0] thr_exp;
    logic [3:0] trig_exp;
    logic [1:0] cls;
    logic [1:0] len_sel;
    logic       thr_below;
    logic       thr_on;
    logic       trig_below;
    logic       trig_on;
    logic       bdf_on;
    logic       port_on;
    logic       run;
  } ctrl_t;

  localparam int CTRL_W  = $bits(ctrl_t);
  localparam int CLR_BIT = 31;

  localparam logic [CTRL_W-1:0] CTRL_RST = CTRL_W'(32'h180);

  localparam logic [2:0] A_CTRL = 3'd0;
  localparam logic [2:0] A_FILT = 3'd1;
  localparam logic [2:0] A_CLO  = 3'd2;
  localparam logic [2:0] A_CHI  = 3'd3;
  localparam logic [2:0] A_STAT = 3'd4;

endpackage

// File: rtl/tlp_bw_regs.sv
module tlp_bw_regs
  import tlp_bw_pkg::*;
#(
  parameter int NPORT = 16,
  parameter int CNT_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [2:0]       cfg_addr,
  input  logic [31:0]      cfg_wdata,
  output logic [31:0]      cfg_rdata,
  output ctrl_t            ctrl,
  output logic [NPORT-1:0] port_map,
  output logic [15:0]      bdf_val,
  output logic             clr,
  input  logic [CNT_W-1:0] cnt,
  input  logic             ovf,
  input  logic             armed,
  input  logic             len_err,
  input  logic             cfg_err
);

  logic [63:0] cnt_wide;
  logic        unused_wbits;

  assign cnt_wide     = 64'(cnt);
  assign unused_wbits = ^cfg_wdata[CLR_BIT-1:CTRL_W];
  assign clr          = cfg_we && (cfg_addr == A_CTRL) && cfg_wdata[CLR_BIT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl     <= ctrl_t'(CTRL_RST);
      port_map <= '0;
      bdf_val  <= '0;
    end else if (cfg_we) begin
      case (cfg_addr)
        A_CTRL: ctrl <= ctrl_t'(cfg_wdata[CTRL_W-1:0]);
        A_FILT: begin
          port_map <= cfg_wdata[NPORT-1:0];
          bdf_val  <= cfg_wdata[31:16];
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    case (cfg_addr)
      A_CTRL:  cfg_rdata = 32'(ctrl);
      A_FILT:  cfg_rdata = {bdf_val, 16'(port_map)};
      A_CLO:   cfg_rdata = cnt_wide[31:0];
      A_CHI:   cfg_rdata = cnt_wide[63:32];
      A_STAT:  cfg_rdata = {28'd0, cfg_err, len_err, armed, ovf};
      default: cfg_rdata = '0;
    endcase
  end

endmodule

// File: rtl/tlp_bw_filter.sv
module tlp_bw_filter
  import tlp_bw_pkg::*;
#(
  parameter int NPORT = 16,
  parameter int HDR_W = 3,
  parameter int PAY_W = 11,
  localparam int PORT_W = $clog2(NPORT),
  localparam int LEN_W  = ((HDR_W > PAY_W) ? HDR_W : PAY_W) + 1,
  localparam int CMP_W  = ((LEN_W > 16) ? LEN_W : 16) + 1
) (
  input  ctrl_t              ctrl,
  input  logic [NPORT-1:0]   port_map,
  input  logic [15:0]        bdf_val,
  input  logic               fire,
  input  logic [PORT_W-1:0]  t_port,
  input  logic [15:0]        t_bdf,
  input  logic [HDR_W-1:0]   t_hdr,
  input  logic [PAY_W-1:0]   t_pay,
  input  logic [1:0]         t_cls,
  input  logic               armed,
  output logic [LEN_W-1:0]   add_amt,
  output logic               cnt_ok,
  output logic               arm_hit,
  output logic               cfg_err,
  output logic               len_err
);

  logic [CMP_W-1:0] tlen, lim_trig, lim_thr;
  logic is_bw, one_port, tgt_ok, base, trig_hit, trig_gate, thr_pass;

  assign is_bw    = (ctrl.cls == CLS_BW);
  assign one_port = ($countones(port_map) == 1);

  // configuration legality depends only on register state
  always_comb begin
    cfg_err = 1'b0;
    if (ctrl.port_on && ctrl.bdf_on) cfg_err = 1'b1;
    if (ctrl.bdf_on && !is_bw) cfg_err = 1'b1;
    if (ctrl.port_on && (ctrl.cls == CLS_TXN || ctrl.cls == CLS_LNK) && !one_port)
      cfg_err = 1'b1;
  end

  assign len_err = (ctrl.len_sel == 2'b00);

  always_comb begin
    if (ctrl.port_on)     tgt_ok = port_map[t_port];
    else if (ctrl.bdf_on) tgt_ok = (t_bdf == bdf_val);
    else                  tgt_ok = 1'b1;
  end

  assign tlen     = CMP_W'(t_hdr) + CMP_W'(t_pay);
  assign lim_trig = CMP_W'(1) << ctrl.trig_exp;
  assign lim_thr  = CMP_W'(1) << ctrl.thr_exp;

  assign trig_hit  = ctrl.trig_below ? (tlen < lim_trig) : (tlen > lim_trig);
  assign trig_gate = !(ctrl.trig_on && is_bw) || armed || trig_hit;
  assign thr_pass  = !(ctrl.thr_on && is_bw) ||
                     (ctrl.thr_below ? (tlen < lim_thr) : (tlen >= lim_thr));

  assign base    = fire && ctrl.run && (t_cls == ctrl.cls) && tgt_ok && !cfg_err;
  assign arm_hit = base && ctrl.trig_on && is_bw && trig_hit;
  assign cnt_ok  = base && trig_gate && thr_pass && !len_err;

  always_comb begin
    case (ctrl.len_sel)
      2'b01:   add_amt = LEN_W'(t_pay);
      2'b10:   add_amt = LEN_W'(t_hdr);
      2'b11:   add_amt = LEN_W'(t_hdr) + LEN_W'(t_pay);
      default: add_amt = '0;
    endcase
  end

endmodule

// File: rtl/tlp_bw_accum.sv
module tlp_bw_accum #(
  parameter int CNT_W = 64,
  parameter int ADD_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             cnt_ok,
  input  logic             arm_hit,
  input  logic [ADD_W-1:0] add_amt,
  output logic [CNT_W-1:0] cnt_q,
  output logic             ovf_q,
  output logic             armed_q
);

  logic [CNT_W:0] sum;

  assign sum = {1'b0, cnt_q} + (CNT_W + 1)'(add_amt);

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      cnt_q   <= '0;
      ovf_q   <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      if (arm_hit) armed_q <= 1'b1;
      if (cnt_ok) begin
        if (sum[CNT_W]) begin
          cnt_q <= '1;
          ovf_q <= 1'b1;
        end else begin
          cnt_q <= sum[CNT_W-1:0];
        end
      end
    end
  end

endmodule

// File: rtl/tlp_bw_counter.sv
module tlp_bw_counter
  import tlp_bw_pkg::*;
#(
  parameter int NPORT = 16,
  parameter int HDR_W = 3,
  parameter int PAY_W = 11,
  parameter int CNT_W = 64,
  localparam int PORT_W = $clog2(NPORT),
  localparam int LEN_W  = ((HDR_W > PAY_W) ? HDR_W : PAY_W) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [PORT_W-1:0] in_port,
  input  logic [15:0]       in_bdf,
  input  logic [HDR_W-1:0]  in_hdr_dw,
  input  logic [PAY_W-1:0]  in_pay_dw,
  input  logic [1:0]        in_cls,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_addr,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata
);

  ctrl_t            ctrl;
  logic [NPORT-1:0] port_map;
  logic [15:0]      bdf_val;
  logic             clr, cnt_ok, arm_hit, cfg_err, len_err;
  logic [LEN_W-1:0] add_amt;
  logic [CNT_W-1:0] cnt_q;
  logic             ovf_q, armed_q, rdy_q;

  always_ff @(posedge clk) begin
    if (!rst_n) rdy_q <= 1'b0;
    else        rdy_q <= 1'b1;
  end
  assign in_ready = rdy_q;

  tlp_bw_regs #(.NPORT(NPORT), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .ctrl(ctrl),
    .port_map(port_map), .bdf_val(bdf_val), .clr(clr), .cnt(cnt_q),
    .ovf(ovf_q), .armed(armed_q), .len_err(len_err), .cfg_err(cfg_err)
  );

  tlp_bw_filter #(.NPORT(NPORT), .HDR_W(HDR_W), .PAY_W(PAY_W)) u_filt (
    .ctrl(ctrl), .port_map(port_map), .bdf_val(bdf_val),
    .fire(in_valid && in_ready), .t_port(in_port), .t_bdf(in_bdf),
    .t_hdr(in_hdr_dw), .t_pay(in_pay_dw), .t_cls(in_cls), .armed(armed_q),
    .add_amt(add_amt), .cnt_ok(cnt_ok), .arm_hit(arm_hit),
    .cfg_err(cfg_err), .len_err(len_err)
  );

  tlp_bw_accum #(.CNT_W(CNT_W), .ADD_W(LEN_W)) u_acc (
    .clk(clk), .rst_n(rst_n), .clr(clr), .cnt_ok(cnt_ok), .arm_hit(arm_hit),
    .add_amt(add_amt), .cnt_q(cnt_q), .ovf_q(ovf_q), .armed_q(armed_q)
  );

endmodule

// File: rtl/tlp_bw_chk.sv
module tlp_bw_chk #(
  parameter int CNT_W = 64
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic             cfg_we,
  input logic [2:0]       cfg_addr,
  input logic [31:0]      cfg_wdata,
  input logic [CNT_W-1:0] cnt,
  input logic             ovf,
  input logic             armed,
  input logic             len_err
);

  logic clr_wr;
  assign clr_wr = cfg_we && (cfg_addr == 3'd0) && cfg_wdata[31];

  p_idle_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (!(in_valid && in_ready) && !clr_wr) |=> $stable(cnt));

  p_clear_r12: assert property (@(posedge clk) disable iff (!rst_n)
    clr_wr |=> (cnt == '0) && !ovf && !armed);

  p_ovf_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !clr_wr) |=> ovf);

  p_no_decrease_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_wr |=> (cnt >= $past(cnt)));

  p_armed_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !clr_wr) |=> armed);

  p_lensel_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (len_err && !clr_wr) |=> $stable(cnt));

endmodule

bind tlp_bw_counter tlp_bw_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
  .cnt(cnt_q), .ovf(ovf_q), .armed(armed_q), .len_err(len_err)
);

// File: tb/sim_tlp_bw_counter.sv
module sim_tlp_bw_counter;

  localparam int CW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [3:0]  in_port = '0;
  logic [15:0] in_bdf = '0;
  logic [2:0]  in_hdr_dw = '0;
  logic [10:0] in_pay_dw = '0;
  logic [1:0]  in_cls = '0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // reference state, built from the requirements
  logic [31:0] m_ctrl = 32'h180;
  logic [15:0] m_map = '0;
  logic [15:0] m_bdf = '0;
  int          m_cnt = 0;
  bit          m_ovf = 1'b0;
  bit          m_armed = 1'b0;
  int          exp_q[$];

  always #10 clk = ~clk;

  tlp_bw_counter #(.CNT_W(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_port(in_port), .in_bdf(in_bdf), .in_hdr_dw(in_hdr_dw),
    .in_pay_dw(in_pay_dw), .in_cls(in_cls), .cfg_we(cfg_we),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    cfg_addr = a;
    #1 d = cfg_rdata;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(posedge clk);
    @(negedge clk);
    cfg_we = 1'b0;
    if (a == 3'd0) begin
      m_ctrl = d & 32'h7FFFF;
      if (d[31]) begin m_cnt = 0; m_ovf = 0; m_armed = 0; end
    end else if (a == 3'd1) begin
      m_map = d[15:0]; m_bdf = d[31:16];
    end
  endtask

  function automatic bit model_cerr();
    bit pon = m_ctrl[1], bon = m_ctrl[2];
    int cls = int'(m_ctrl[10:9]);
    if (pon && bon) return 1;
    if (bon && cls != 0) return 1;
    if (pon && (cls == 2 || cls == 3) && $countones(m_map) != 1) return 1;
    return 0;
  endfunction

  // driver: sends one beat and pushes the expected counter value
  task automatic send(input int port, input int bdf, input int hdr, input int pay, input int cls);
    int len = hdr + pay;
    int scls = int'(m_ctrl[10:9]);
    bit bw = (scls == 0);
    bit tgt, base, hit, gate, thr;
    int tlim = 1 << m_ctrl[14:11];
    int hlim = 1 << m_ctrl[18:15];
    int add;
    in_valid = 1'b1; in_port = 4'(port); in_bdf = 16'(bdf);
    in_hdr_dw = 3'(hdr); in_pay_dw = 11'(pay); in_cls = 2'(cls);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    if (m_ctrl[1])      tgt = m_map[port];
    else if (m_ctrl[2]) tgt = (bdf == int'(m_bdf));
    else                tgt = 1;
    base = m_ctrl[0] && (cls == scls) && tgt && !model_cerr();
    hit  = m_ctrl[4] ? (len < tlim) : (len > tlim);
    gate = !(m_ctrl[3] && bw) || m_armed || hit;
    thr  = !(m_ctrl[5] && bw) || (m_ctrl[6] ? (len < hlim) : (len >= hlim));
    case (m_ctrl[8:7])
      2'b01: add = pay;
      2'b10: add = hdr;
      2'b11: add = len;
      default: add = 0;
    endcase
    if (base && m_ctrl[3] && bw && hit) m_armed = 1;
    if (base && gate && thr && m_ctrl[8:7] != 2'b00) begin
      if (m_cnt + add > 65535) begin m_cnt = 65535; m_ovf = 1; end
      else m_cnt = m_cnt + add;
    end
    exp_q.push_back(m_cnt);
  endtask

  // monitor: pops the expected value and compares with the counter halves
  task automatic mon(input string req);
    logic [31:0] lo, hi;
    int e;
    e = exp_q.pop_front();
    rd(3'd2, lo);
    rd(3'd3, hi);
    check(req, lo, 32'(e));
    check(req, hi, 32'd0);
  endtask

  task automatic chk_stat(input string req);
    logic [31:0] s;
    rd(3'd4, s);
    check(req, s, {28'd0, model_cerr(), (m_ctrl[8:7] == 2'b00), m_armed, m_ovf});
  endtask

  initial begin
    logic [31:0] d;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset values
    rd(3'd0, d); check("R1 ctrl", d, 32'h180);
    rd(3'd1, d); check("R1 filt", d, 32'h0);
    rd(3'd2, d); check("R1 cnt", d, 32'h0);
    rd(3'd4, d); check("R1 stat", d, 32'h0);
    check("R13 ready", 32'(in_ready), 32'd1);

    // R2 run off
    send(0, 0, 4, 16, 0); mon("R2 run off");
    wr(3'd0, 32'h181);
    send(0, 0, 4, 16, 0); mon("R3 both");
    send(0, 0, 4, 16, 1); mon("R2 class mismatch");
    // R13 idle cycles with fields set but valid low
    in_pay_dw = 11'd99;
    repeat (3) @(negedge clk);
    exp_q.push_back(m_cnt); mon("R13 idle");

    wr(3'd0, 32'h081); send(0, 0, 4, 16, 0); mon("R3 payload");
    wr(3'd0, 32'h101); send(0, 0, 4, 16, 0); mon("R3 header");
    wr(3'd0, 32'h001); send(0, 0, 4, 16, 0); mon("R4 hold");
    chk_stat("R4 flag");

    // R5 port bitmap
    wr(3'd1, 32'h0000_0101);
    wr(3'd0, 32'h183);
    send(8, 0, 3, 5, 0); mon("R5 port hit");
    send(3, 0, 3, 5, 0); mon("R5 port miss");

    // R6 single-port rule
    wr(3'd0, 32'h583); chk_stat("R6 cfg err");
    send(0, 0, 3, 5, 2); mon("R6 blocked");
    wr(3'd1, 32'h0000_0004);
    send(2, 0, 3, 5, 2); mon("R6 one port");
    chk_stat("R6 no err");
    wr(3'd1, 32'h0000_0101);
    wr(3'd0, 32'h383);
    send(8, 0, 3, 5, 1); mon("R6 app multi");

    // R7 BDF filter
    wr(3'd1, 32'h3900_0000);
    wr(3'd0, 32'h185);
    send(1, 16'h3900, 4, 6, 0); mon("R7 bdf match");
    send(1, 16'h3901, 4, 6, 0); mon("R7 bdf miss");
    wr(3'd0, 32'h187); chk_stat("R7 both on");
    send(0, 16'h3900, 4, 6, 0); mon("R7 both blocked");
    wr(3'd0, 32'h385); chk_stat("R7 non-bw");

    // R12 clear
    wr(3'd0, 32'h8000_0181);
    exp_q.push_back(0); mon("R12 clear");
    rd(3'd0, d); check("R12 fields kept", d, 32'h181);

    // R8 trigger above 16 DW
    wr(3'd0, 32'h2189);
    send(0, 0, 4, 4, 0);  mon("R8 short");
    send(0, 0, 4, 12, 0); mon("R8 equal");
    chk_stat("R8 not armed");
    send(0, 0, 4, 16, 0); mon("R8 fire");
    chk_stat("R8 armed");
    send(0, 0, 4, 4, 0);  mon("R8 stays");

    // R9 trigger below 16 DW
    wr(3'd0, 32'h8000_2199);
    send(0, 0, 4, 16, 0); mon("R9 long");
    send(0, 0, 4, 8, 0);  mon("R9 fire");
    send(0, 0, 4, 30, 0); mon("R9 stays");
    chk_stat("R9 armed");

    // R10 threshold 16 DW
    wr(3'd0, 32'h8002_01A1);
    send(0, 0, 4, 12, 0); mon("R10 at limit");
    send(0, 0, 4, 11, 0); mon("R10 below");
    wr(3'd0, 32'h201E1);
    send(0, 0, 4, 11, 0); mon("R10 below mode1");
    send(0, 0, 4, 12, 0); mon("R10 at limit mode1");
    wr(3'd0, 32'h203E1);
    send(0, 0, 4, 12, 1); mon("R10 app ignores");

    // R11 saturation
    wr(3'd0, 32'h8000_0181);
    for (int i = 0; i < 32; i++) begin
      send(0, 0, 4, 2047, 0); mon("R11 accumulate");
    end
    chk_stat("R11 overflow");
    send(0, 0, 4, 2047, 0); mon("R11 pinned");
    wr(3'd0, 32'h8000_0181);
    chk_stat("R12 ovf cleared");
    exp_q.push_back(0); mon("R12 zero");

    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 200000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule